// File: doc/BRIEF.md
# Streaming Dot-Product Accumulator

This engine forms the inner product of two vectors of signed 32-bit integers held in a word-addressed memory and returns it as a signed 64-bit value. A one-cycle start pulse supplies a byte base address for each vector and a signed 32-bit element count. The engine then fetches one element of each vector per clock over a pair of synchronous read lanes that share one request strobe and return data one clock after the request.

Each fetched pair passes through a registered multiply stage and then a registered accumulate stage. Integer arithmetic follows the C rules for `int` and `long long`. The product of two 32-bit operands keeps only its low 32 bits. That truncated value is sign-extended before it is added to the 64-bit running sum. When the count is zero or negative, the engine makes no fetches and reports zero. When the pipeline has drained, a one-cycle done pulse marks the result as final. The result then holds until the next accepted start.

Top module: `dotp_engine`

## Requirements
- R1: An accepted start clears the running sum. At done, `result` equals the sum over all fetched pairs, taken in 64-bit two's complement.
- R2: For a count n > 0, exactly n read requests are issued between an accepted start and its done.
- R3: The k-th request of a run (k counting from 0) carries addresses base_a + 4k and base_b + 4k, so elements are consumed in ascending address order.
- R4: Each product is the signed 32x32 product truncated to its low 32 bits and then sign-extended to 64 bits before it is added. For example, 0x7FFFFFFF times 2 contributes -2.
- R5: A count of zero or less (the count is read as signed) issues no read request. Done rises one clock after the start is accepted, and `result` is zero.
- R6: A start pulse while `busy` is high is ignored. The run in progress keeps its addresses, its count and its result.
- R7: Done is high for exactly one clock. While the engine is idle and no start arrives, `result` does not change.
- R8: Read requests of a run with a positive count occupy consecutive clocks, one pair per clock.
- R9: Done rises exactly four clocks after the clock of the final read request: one clock for the memory, one for the multiply, one for the accumulate, and one for the drain check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted only when idle |
| base_a | input | 32 | Byte address of the first element of vector A |
| base_b | input | 32 | Byte address of the first element of vector B |
| len | input | 32 | Signed element count |
| busy | output | 1 | High from an accepted start until done |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Signed 64-bit dot product |
| rd_req | output | 1 | Read request strobe for both lanes |
| rd_addr_a | output | 32 | Read byte address, lane A |
| rd_addr_b | output | 32 | Read byte address, lane B |
| rd_data_a | input | 32 | Read data, lane A, one clock after the request |
| rd_data_b | input | 32 | Read data, lane B, one clock after the request |

## Verification
The hardest case to reach from the ports is a second start pulse that arrives while a run is still fetching and that carries a different base address and count. The case is hard because it needs an exact timing overlap. The driver times such a pulse a few clocks into a long run. The scoreboard then confirms that every fetch address still follows the first job and that the final sum matches only that job. Operand patterns that overflow 32 bits are placed in memory on purpose, including the most negative value and the most positive value. With these patterns a sum built without truncation and sign extension would give a different result.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

    localparam int DEF_DATA_W     = 32;
    localparam int DEF_ACC_W      = 64;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_ELEM_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_e;

endpackage

// File: rtl/dotp_issue.sv
module dotp_issue
    import dotp_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int CNT_W      = DEF_DATA_W,
    parameter int ELEM_BYTES = DEF_ELEM_BYTES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       base_a,
    input  logic [ADDR_W-1:0]       base_b,
    input  logic signed [CNT_W-1:0] len,
    input  logic                    pipe_empty,
    output logic                    accept,
    output logic                    rd_req,
    output logic [ADDR_W-1:0]       rd_addr_a,
    output logic [ADDR_W-1:0]       rd_addr_b,
    output logic                    busy,
    output logic                    done
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ELEM_BYTES);

    run_state_e              state;
    logic [ADDR_W-1:0]       ptr_a, ptr_b;
    logic signed [CNT_W-1:0] left;

    assign accept    = (state == ST_IDLE) && start;
    assign rd_req    = (state == ST_RUN);
    assign busy      = (state != ST_IDLE);
    assign rd_addr_a = ptr_a;
    assign rd_addr_b = ptr_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr_a <= '0;
            ptr_b <= '0;
            left  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ptr_a <= base_a;
                        ptr_b <= base_b;
                        left  <= len;
                        state <= (len > 0) ? ST_RUN : ST_DRAIN;
                    end
                end
                ST_RUN: begin
                    ptr_a <= ptr_a + STEP;
                    ptr_b <= ptr_b + STEP;
                    left  <= left - 1'b1;
                    if (left <= 1) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (pipe_empty) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: consecutive fetches step by one element on both lanes
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && $past(rd_req)) |->
            (rd_addr_a == $past(rd_addr_a) + STEP) && (rd_addr_b == $past(rd_addr_b) + STEP));

    // R5: a non-positive count never produces a fetch
    p_nonpos_len_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && (len <= 0)) |=> !rd_req);

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a start seen while busy does not reload the pointers mid-run
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && start && rd_req && $past(rd_req)) |=>
            (rd_addr_a == $past(rd_addr_a) + STEP) || !rd_req);

endmodule

// File: rtl/dotp_mul.sv
module dotp_mul
    import dotp_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] op_a,
    input  logic signed [DATA_W-1:0] op_b,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] prod
);

    localparam int FULL_W = 2 * DATA_W;

    logic signed [FULL_W-1:0] full;

    assign full = op_a * op_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            prod    <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) prod <= full[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/dotp_acc.sv
module dotp_acc
    import dotp_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ACC_W  = DEF_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] term,
    output logic signed [ACC_W-1:0]  sum
);

    logic signed [ACC_W-1:0] term_ext;

    generate
        if (ACC_W > DATA_W) begin : g_widen
            assign term_ext = {{(ACC_W-DATA_W){term[DATA_W-1]}}, term};
        end else begin : g_narrow
            assign term_ext = term[ACC_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else if (clear) begin
            sum <= '0;
        end else if (in_vld) begin
            sum <= sum + term_ext;
        end
    end

    // R1: an accepted start leaves a zero sum behind it
    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        clear |=> (sum == '0));

endmodule

// File: rtl/dotp_engine.sv
module dotp_engine
    import dotp_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int ACC_W      = DEF_ACC_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int ELEM_BYTES = DEF_ELEM_BYTES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        base_a,
    input  logic [ADDR_W-1:0]        base_b,
    input  logic signed [DATA_W-1:0] len,
    output logic                     busy,
    output logic                     done,
    output logic signed [ACC_W-1:0]  result,
    output logic                     rd_req,
    output logic [ADDR_W-1:0]        rd_addr_a,
    output logic [ADDR_W-1:0]        rd_addr_b,
    input  logic signed [DATA_W-1:0] rd_data_a,
    input  logic signed [DATA_W-1:0] rd_data_b
);

    logic                     accept;
    logic                     data_vld;
    logic                     prod_vld;
    logic signed [DATA_W-1:0] prod;
    logic                     pipe_empty;

    assign pipe_empty = !data_vld && !prod_vld;

    always_ff @(posedge clk) begin
        if (rst) data_vld <= 1'b0;
        else     data_vld <= rd_req;
    end

    dotp_issue #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (DATA_W),
        .ELEM_BYTES(ELEM_BYTES)
    ) u_issue (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base_a    (base_a),
        .base_b    (base_b),
        .len       (len),
        .pipe_empty(pipe_empty),
        .accept    (accept),
        .rd_req    (rd_req),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .busy      (busy),
        .done      (done)
    );

    dotp_mul #(.DATA_W(DATA_W)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .in_vld (data_vld),
        .op_a   (rd_data_a),
        .op_b   (rd_data_b),
        .out_vld(prod_vld),
        .prod   (prod)
    );

    dotp_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .in_vld(prod_vld),
        .term  (prod),
        .sum   (result)
    );

    // R9: done only once both pipeline stages are empty
    p_drain_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!data_vld && !prod_vld && !rd_req));

    // R7: an idle engine holds its result until a start arrives
    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !done) |=> $stable(result));

endmodule

// File: tb/dotp_engine_bench.sv
`timescale 1ns/100ps
module dotp_engine_bench;

    typedef struct {
        longint      res;
        int          n;
        logic [31:0] ba;
        logic [31:0] bb;
    } job_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_a = '0, base_b = '0;
    logic signed [31:0] len = '0;
    logic        busy, done, rd_req;
    logic signed [63:0] result;
    logic [31:0] rd_addr_a, rd_addr_b;
    logic signed [31:0] rd_data_a, rd_data_b;

    int mem [256];
    job_t q[$];
    int nvec = 0, nfail = 0;
    int cyc = 0, start_cyc = 0, last_req = 0, rd_cnt = 0;
    bit prev_done = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dotp_engine u_dotp_engine (
        .clk(clk), .rst(rst), .start(start), .base_a(base_a), .base_b(base_b),
        .len(len), .busy(busy), .done(done), .result(result), .rd_req(rd_req),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
    );

    always @(posedge clk) begin
        if (rd_req) begin
            rd_data_a <= mem[rd_addr_a[9:2]];
            rd_data_b <= mem[rd_addr_b[9:2]];
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    function automatic longint model(input logic [31:0] ba, input logic [31:0] bb, input int n);
        longint s = 0;
        for (int i = 0; i < n; i++) begin
            int p;
            p = mem[(ba[9:2] + i) & 255] * mem[(bb[9:2] + i) & 255];
            s += longint'(p);
        end
        return s;
    endfunction

    // monitor: pops the scoreboard on done, follows fetch addresses
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_req) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected fetch", 1, 0);
                end else begin
                    check(rd_addr_a == q[0].ba + 32'(4 * rd_cnt), "R3 addr A",
                          rd_addr_a, q[0].ba + 32'(4 * rd_cnt));
                    check(rd_addr_b == q[0].bb + 32'(4 * rd_cnt), "R3 addr B",
                          rd_addr_b, q[0].bb + 32'(4 * rd_cnt));
                    if (rd_cnt > 0)
                        check(last_req == cyc - 1, "R8 back-to-back fetch", cyc - last_req, 1);
                end
                rd_cnt++;
                last_req = cyc;
            end
            check(!(done && prev_done), "R7 done width", 2, 1);
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7 spurious done", 1, 0);
                end else begin
                    job_t j;
                    j = q.pop_front();
                    check(result == j.res, "R1/R4 result", result, j.res);
                    if (j.n > 0) begin
                        check(rd_cnt == j.n, "R2 fetch count", rd_cnt, j.n);
                        check(cyc - last_req == 4, "R9 drain latency", cyc - last_req, 4);
                    end else begin
                        check(rd_cnt == 0, "R5 no fetch", rd_cnt, 0);
                        check(cyc - start_cyc == 1, "R5 done latency", cyc - start_cyc, 1);
                    end
                end
                rd_cnt = 0;
            end
            prev_done = done;
        end
    end

    // driver: pushes the expected item, then launches the job
    task automatic run_job(input logic [31:0] ba, input logic [31:0] bb, input int n, input bit meddle);
        job_t j;
        j.n   = (n > 0) ? n : 0;
        j.ba  = ba;
        j.bb  = bb;
        j.res = model(ba, bb, j.n);
        q.push_back(j);
        @(negedge clk);
        start = 1'b1; base_a = ba; base_b = bb; len = n;
        start_cyc = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        if (meddle) begin
            // R6: foreign start while the run is fetching
            repeat (3) @(negedge clk);
            start = 1'b1; base_a = 32'h0; base_b = 32'h40; len = 3;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
        check(result == j.res, "R7 result hold", result, j.res);
        check(!busy, "R6 idle after run", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 1, 0);
        wrap_up();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E3779B1) ^ (i << 7);
        mem[16] = 32'h7FFFFFFF; mem[48] = 2;
        mem[17] = 32'h80000000; mem[49] = 32'h80000000;
        mem[18] = 32'h7FFFFFFF; mem[50] = 32'h7FFFFFFF;
        mem[19] = -7;           mem[51] = 32'h10000001;
        mem[20] = 32'h80000000; mem[52] = -1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done, "R7 reset done", done, 0);
        check(!busy, "R6 reset busy", busy, 0);
        check(!rd_req, "R2 reset req", rd_req, 0);
        check(result == 0, "R1 reset result", result, 0);

        run_job(32'h040, 32'h0C0, 1, 1'b0);       // R4: 0x7FFFFFFF*2 wraps to -2
        run_job(32'h040, 32'h0C0, 5, 1'b0);       // R4: extreme operands
        run_job(32'h100, 32'h200, 0, 1'b0);       // R5: zero count
        run_job(32'h100, 32'h200, -5, 1'b0);      // R5: negative count
        run_job(32'h000, 32'h300, 40, 1'b0);      // R1/R2: long run
        run_job(32'h080, 32'h180, 20, 1'b1);      // R6: start while busy
        run_job(32'h3F0, 32'h010, 8, 1'b0);       // R3: address wrap in bench memory
        run_job(32'h100, 32'h104, 2, 1'b0);       // R8: short run right after
        run_job(32'h000, 32'h000, 32'h80000000, 1'b0); // R5: most negative count

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R7 jobs completed", q.size(), 0);
        wrap_up();
    end

endmodule